// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Controller

This block sits beside a calendar time counter and its alarm comparator and turns their activity into two interrupt lines for a processor. Seven one-cycle rollover pulses (tenths of a second up to months) and one compare-match level come in. A byte-wide register bus selects which of the eight sources may raise the active-high interrupt. Software reads a status register to see which sources fired, and the interrupt clears when that read ends.

The second output is an active-low standby alarm. It follows the compare-match level directly whenever a one-bit enable is set, so turning the enable on while a match already exists pulls the line low at once. Events that arrive while the status register is being read are held back and appear as soon as the read finishes, so none of them is lost.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset the mask register, status register and standby enable are all zero, `irq_out` is low and `stby_irq_n` is high.
- R2: Source bit order in both the mask register (write/read address 11h) and the status register (read address 10h) is bit 0 compare, bit 1 tenths, bit 2 seconds, bit 3 minutes, bit 4 hours, bit 5 days, bit 6 weeks, bit 7 months; `roll_pulse[k]` feeds bit k+1. A source whose mask bit is 0 sets no status bit.
- R3: An enabled event sets its status bit on the clock edge that samples it, and `irq_out` is high from the next cycle until the status register is cleared.
- R4: While `bus_rd` is high with address 10h, `bus_rdata` shows the status bits (1 for each source that fired) and they do not change for the whole read.
- R5: On the first clock edge after a status read ends (strobe low or address moved), the status register clears and `irq_out` falls, unless R6 applies.
- R6: An enabled event that arrives during a status read is held and becomes the status content at the end of that read, so `irq_out` stays high.
- R7: `stby_irq_n` is low exactly while the standby enable is 1 and `cmp_match` is high; it reacts to the level within the same cycle, so enabling it during a match asserts it on the cycle after the write.
- R8: The standby enable is written from data bit 0 at address 16h and reads back there in bit 0; the mask reads back at 11h; any other address, or no read strobe, gives `bus_rdata` = 0.
- R9: The compare source sets its status bit only on a rising edge of `cmp_match`; a held match sets it once.
- R10: Writes to the status address have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| roll_pulse | input | 7 | One-cycle rollover pulses, tenths through months |
| cmp_match | input | 1 | Alarm compare-match level |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe, held for the whole read |
| bus_rdata | output | 8 | Read data, zero when not reading |
| irq_out | output | 1 | Periodic/alarm interrupt, active high |
| stby_irq_n | output | 1 | Standby alarm interrupt, active low |

## Verification
The bench pulses masked and unmasked rollover sources singly and together, which separates a wrong bit order or an ignored mask from a correct one. Reads are held across incoming events and then released, which tells a clear on the leading edge, or a clear that drops events, from the held-and-reshown behaviour. The compare input is held high across several cycles and toggled, distinguishing edge capture for status from the level-following standby line, and the standby enable is switched both before and during a match.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned ADDR_W_DEF = 5;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned N_ROLL_DEF = 7;

  localparam logic [ADDR_W_DEF-1:0] ADR_STATUS = 5'h10;
  localparam logic [ADDR_W_DEF-1:0] ADR_MASK   = 5'h11;
  localparam logic [ADDR_W_DEF-1:0] ADR_STBY   = 5'h16;

  typedef enum int unsigned {
    SRC_CMP   = 0,
    SRC_TENTH = 1,
    SRC_SEC   = 2,
    SRC_MIN   = 3,
    SRC_HOUR  = 4,
    SRC_DAY   = 5,
    SRC_WEEK  = 6,
    SRC_MONTH = 7
  } src_e;

endpackage

// File: rtl/irqc_event.sv
module irqc_event #(
  parameter int unsigned N_ROLL = irqc_pkg::N_ROLL_DEF,
  localparam int unsigned N_SRC = N_ROLL + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ROLL-1:0] roll_i,
  input  logic             cmp_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             cmp_rise_o,
  output logic [N_SRC-1:0] ev_o
);

  logic cmp_q;

  function automatic logic [N_SRC-1:0] gate_events(
    input logic [N_ROLL-1:0] roll,
    input logic              rise,
    input logic [N_SRC-1:0]  mask
  );
    return {roll, rise} & mask;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_i;
  end

  assign cmp_rise_o = cmp_i & ~cmp_q;
  assign ev_o       = gate_events(roll_i, cmp_rise_o, mask_i);

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned N_SRC = irqc_pkg::N_ROLL_DEF + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_i,
  input  logic             rd_active_i,
  output logic             rd_trail_o,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] pend_o
);

  logic             rd_q;
  logic [N_SRC-1:0] status_q, pend_q;

  function automatic logic [N_SRC-1:0] status_next(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] held,
    input logic [N_SRC-1:0] ev,
    input logic             busy,
    input logic             trail
  );
    if (trail)     return held | ev;
    else if (busy) return cur;
    else           return cur | ev;
  endfunction

  function automatic logic [N_SRC-1:0] pend_next(
    input logic [N_SRC-1:0] held,
    input logic [N_SRC-1:0] ev,
    input logic             busy
  );
    return busy ? (held | ev) : '0;
  endfunction

  assign rd_trail_o = rd_q & ~rd_active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      status_q <= '0;
      pend_q   <= '0;
    end else begin
      rd_q     <= rd_active_i;
      status_q <= status_next(status_q, pend_q, ev_i, rd_active_i, rd_trail_o);
      pend_q   <= pend_next(pend_q, ev_i, rd_active_i);
    end
  end

  assign status_o = status_q;
  assign pend_o   = pend_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned ADDR_W = irqc_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = irqc_pkg::DATA_W_DEF,
  parameter int unsigned N_SRC  = irqc_pkg::N_ROLL_DEF + 1,
  parameter logic [ADDR_W-1:0] A_STATUS = irqc_pkg::ADR_STATUS,
  parameter logic [ADDR_W-1:0] A_MASK   = irqc_pkg::ADR_MASK,
  parameter logic [ADDR_W-1:0] A_STBY   = irqc_pkg::ADR_STBY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic              sten_o,
  output logic              rd_active_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [N_SRC-1:0] mask_q;
  logic             sten_q;

  function automatic logic [DATA_W-1:0] read_mux(
    input logic [ADDR_W-1:0] a,
    input logic [N_SRC-1:0]  st,
    input logic [N_SRC-1:0]  mk,
    input logic              en
  );
    if (a == A_STATUS)    return DATA_W'(st);
    else if (a == A_MASK) return DATA_W'(mk);
    else if (a == A_STBY) return DATA_W'(en);
    else                  return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sten_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_MASK) mask_q <= wdata_i[N_SRC-1:0];
      if (addr_i == A_STBY) sten_q <= wdata_i[0];
    end
  end

  assign rd_active_o = rd_i & (addr_i == A_STATUS);
  assign rdata_o     = rd_i ? read_mux(addr_i, status_i, mask_q, sten_q) : '0;
  assign mask_o      = mask_q;
  assign sten_o      = sten_q;

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl #(
  parameter int unsigned ADDR_W = irqc_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = irqc_pkg::DATA_W_DEF,
  parameter int unsigned N_ROLL = irqc_pkg::N_ROLL_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ROLL-1:0] roll_pulse,
  input  logic              cmp_match,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              stby_irq_n
);

  localparam int unsigned N_SRC = N_ROLL + 1;

  // named internal events, visible to the bound checker
  logic [N_SRC-1:0] ev_masked;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] pend_q;
  logic             cmp_rise;
  logic             rd_active;
  logic             rd_trail;
  logic             sten_q;

  irqc_event #(.N_ROLL(N_ROLL)) u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .roll_i     (roll_pulse),
    .cmp_i      (cmp_match),
    .mask_i     (mask_q),
    .cmp_rise_o (cmp_rise),
    .ev_o       (ev_masked)
  );

  irqc_status #(.N_SRC(N_SRC)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev_masked),
    .rd_active_i (rd_active),
    .rd_trail_o  (rd_trail),
    .status_o    (status_q),
    .pend_o      (pend_q)
  );

  irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata),
    .wr_i        (bus_wr),
    .rd_i        (bus_rd),
    .status_i    (status_q),
    .mask_o      (mask_q),
    .sten_o      (sten_q),
    .rd_active_o (rd_active),
    .rdata_o     (bus_rdata)
  );

  assign irq_out    = |status_q;
  assign stby_irq_n = ~(sten_q & cmp_match);

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned N_SRC = irqc_pkg::N_ROLL_DEF + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] ev_masked,
  input logic [N_SRC-1:0] status_q,
  input logic [N_SRC-1:0] pend_q,
  input logic             rd_active,
  input logic             rd_trail,
  input logic             sten_q,
  input logic             cmp_match,
  input logic             irq_out,
  input logic             stby_irq_n
);

  // R3: an enabled event outside a read raises the interrupt next cycle
  a_r3_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_masked) && !rd_active) |=> irq_out);

  // R4: status frozen while a read continues
  a_r4_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active)) |-> $stable(status_q));

  // R5: end of read with nothing held clears the interrupt
  a_r5_trail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_trail && !(|pend_q) && !(|ev_masked)) |=> !irq_out);

  // R6: an event during a read is held
  a_r6_event_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && (|ev_masked)) |=> (|pend_q));

  // R7: enabling during a match pulls the standby line low at once
  a_r7_enable_in_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sten_q) && cmp_match) |-> !stby_irq_n);

endmodule

bind tick_irq_ctrl irqc_chk #(.N_SRC(N_ROLL + 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_masked  (ev_masked),
  .status_q   (status_q),
  .pend_q     (pend_q),
  .rd_active  (rd_active),
  .rd_trail   (rd_trail),
  .sten_q     (sten_q),
  .cmp_match  (cmp_match),
  .irq_out    (irq_out),
  .stby_irq_n (stby_irq_n)
);

// File: tb/sim_tick_irq_ctrl.sv
module sim_tick_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] roll_pulse = '0;
  logic       cmp_match = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_out;
  logic       stby_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .roll_pulse(roll_pulse), .cmp_match(cmp_match),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .stby_irq_n(stby_irq_n)
  );

  // behavioural reference state
  int m_mask, m_stat, m_held, m_sten;
  bit m_cmp_last, m_in_read;

  always @(posedge clk) begin
    int fired;
    bit now_read;
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_held = 0; m_sten = 0;
      m_cmp_last = 0; m_in_read = 0;
    end else begin
      fired = int'(roll_pulse) * 2;
      if (cmp_match && !m_cmp_last) fired = fired + 1;
      fired = fired & m_mask;
      now_read = bus_rd && (bus_addr == 5'h10);
      if (m_in_read && !now_read) begin
        m_stat = m_held | fired;
        m_held = 0;
      end else if (now_read) begin
        m_held = m_held | fired;
      end else begin
        m_stat = m_stat | fired;
      end
      if (bus_wr && bus_addr == 5'h11) m_mask = int'(bus_wdata);
      if (bus_wr && bus_addr == 5'h16) m_sten = int'(bus_wdata[0]);
      m_cmp_last = cmp_match;
      m_in_read  = now_read;
    end
  end

  function automatic logic [7:0] model_rdata();
    if (!bus_rd) return 8'h00;
    case (bus_addr)
      5'h10:   return 8'(m_stat);
      5'h11:   return 8'(m_mask);
      5'h16:   return 8'(m_sten);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/stimulus cycle: drive at negedge, compare against the model just after
  task automatic cyc(input logic [6:0] rp, input logic cm, input logic rd,
                     input logic wr, input logic [4:0] a, input logic [7:0] wd);
    @(negedge clk);
    roll_pulse = rp; cmp_match = cm; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd;
    #1;
    if (rst_n) begin
      chk("R3 irq_out vs model", 8'(irq_out), 8'(m_stat != 0));
      chk("R4 bus_rdata vs model", bus_rdata, model_rdata());
      chk("R7 stby_irq_n vs model", 8'(stby_irq_n), 8'(!(m_sten != 0 && cmp_match)));
    end
  endtask

  task automatic idle(input logic cm);
    cyc('0, cm, 1'b0, 1'b0, 5'h00, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(0); idle(0);
    chk("R1 irq low in reset", 8'(irq_out), 8'h0);
    chk("R1 standby high in reset", 8'(stby_irq_n), 8'h1);
    @(negedge clk); rst_n = 1'b1;
    cyc('0, 0, 1, 0, 5'h11, 0); chk("R1 mask zero", bus_rdata, 8'h00);
    cyc('0, 0, 1, 0, 5'h16, 0); chk("R1 standby enable zero", bus_rdata, 8'h00);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R1 status zero", bus_rdata, 8'h00);
    idle(0);

    // R2: nothing enabled, every source fires
    cyc(7'h7F, 1, 0, 0, 0, 0);
    idle(0);
    chk("R2 masked sources leave irq low", 8'(irq_out), 8'h0);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R2 masked status empty", bus_rdata, 8'h00);
    idle(0);

    // enable seconds only (bit 2)
    cyc('0, 0, 0, 1, 5'h11, 8'h04);
    cyc('0, 0, 1, 0, 5'h11, 0); chk("R8 mask reads back", bus_rdata, 8'h04);
    cyc(7'b0000001, 0, 0, 0, 0, 0);
    idle(0); chk("R2 tenths disabled", 8'(irq_out), 8'h0);
    cyc(7'b0000010, 0, 0, 0, 0, 0);
    chk("R3 irq not yet on sampling cycle", 8'(irq_out), 8'h0);
    idle(0); chk("R3 seconds raises irq", 8'(irq_out), 8'h1);

    // R4/R6: read held across a new event
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R4 status shows seconds", bus_rdata, 8'h04);
    cyc(7'b0000010, 0, 1, 0, 5'h10, 0); chk("R4 read data stable", bus_rdata, 8'h04);
    idle(0); chk("R5 irq holds until edge after read", 8'(irq_out), 8'h1);
    idle(0); chk("R6 held event keeps irq", 8'(irq_out), 8'h1);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R6 held event shown", bus_rdata, 8'h04);
    idle(0);
    idle(0); chk("R5 irq clears after read", 8'(irq_out), 8'h0);

    // R2 bit order with everything enabled
    cyc('0, 0, 0, 1, 5'h11, 8'hFF);
    cyc(7'b1000001, 0, 0, 0, 0, 0);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R2 month and tenths bits", bus_rdata, 8'h82);
    idle(0);
    cyc(7'b0111110, 0, 0, 0, 0, 0);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R2 middle sources", bus_rdata, 8'h7C);
    idle(0);

    // R9: compare captured on its rising edge only
    cyc('0, 1, 0, 0, 0, 0);
    cyc('0, 1, 1, 0, 5'h10, 0); chk("R9 compare bit", bus_rdata, 8'h01);
    idle(1);
    idle(1); chk("R9 held match does not refire", 8'(irq_out), 8'h0);
    idle(0);
    idle(1);
    idle(1); chk("R9 new rising edge refires", 8'(irq_out), 8'h1);
    cyc('0, 0, 1, 0, 5'h10, 0);
    idle(0); idle(0);

    // R7: standby line follows the level
    cyc('0, 0, 0, 1, 5'h16, 8'h01);
    idle(0); chk("R7 enabled without match", 8'(stby_irq_n), 8'h1);
    cyc('0, 1, 0, 0, 0, 0); chk("R7 match pulls low same cycle", 8'(stby_irq_n), 8'h0);
    cyc('0, 1, 0, 1, 5'h16, 8'h00);
    idle(1); chk("R7 disabled during match", 8'(stby_irq_n), 8'h1);
    cyc('0, 1, 0, 1, 5'h16, 8'hFE);
    idle(1); chk("R8 only data bit 0 enables", 8'(stby_irq_n), 8'h1);
    cyc('0, 1, 0, 1, 5'h16, 8'h01);
    chk("R7 not before the write edge", 8'(stby_irq_n), 8'h1);
    idle(1); chk("R7 enable in match asserts at once", 8'(stby_irq_n), 8'h0);
    cyc('0, 1, 1, 0, 5'h16, 0); chk("R8 standby enable reads back", bus_rdata, 8'h01);
    cyc('0, 1, 1, 0, 5'h10, 0);
    idle(0); idle(0);

    // R10: status writes ignored; R8 unmapped and idle reads
    cyc('0, 0, 0, 1, 5'h10, 8'hFF);
    idle(0); chk("R10 status write ignored", 8'(irq_out), 8'h0);
    cyc('0, 0, 1, 0, 5'h10, 0); chk("R10 status still empty", bus_rdata, 8'h00);
    cyc('0, 0, 1, 0, 5'h03, 0); chk("R8 unmapped read zero", bus_rdata, 8'h00);
    idle(0); chk("R8 no strobe gives zero", bus_rdata, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule